// File: doc/BRIEF.md
# Trap dispatch and privilege controller

This control unit sits beside the datapath of a 16-bit processor. It carries out the trap instruction and the matching return. A trap takes an 8-bit vector from the instruction, reads a word from a 256-entry table at the bottom of memory (addresses 0x0000 to 0x00FF), and sends the PC to that word. The already-incremented PC is kept in general register 7 as the return link. A return reloads the PC from register 7.

The unit also keeps a one-bit execution mode, where 1 means privileged and 0 means user. A trap raises the mode for the length of the service routine and saves the previous mode in a one-deep slot. The return puts that saved mode back. System operations cover I/O, memory-mapped register loads, clock reset and halt, and only privileged code may run them. If user code attempts one, the unit withholds its write-back permission and flags the violation.

The datapath presents an instruction with a one-cycle `ir_valid` strobe. The memory is single-port with a read latency of one cycle. With `PRIV_ENFORCE` cleared, the mode stays privileged and nothing is blocked.

Top module: `trap_ctrl`

## Requirements
- R1: In the commit cycle of a trap, `rf_we` is high, `rf_waddr` is 7 and `rf_wdata` equals the `pc_cur` value that was sampled when the trap was accepted.
- R2: In the cycle after a trap is accepted, `mem_rd` is high and `mem_addr` is the vector `ir[7:0]` zero-extended to 16 bits. Vectors 0x00 through 0xFF are all valid.
- R3: `pc_we` and `rf_we` rise together in the third cycle after acceptance. `pc_wdata` then equals the memory word read at the vector address, and not the address itself.
- R4: A trap is `ir` = 0xF0vv, where bits [15:12] are 1111 and bits [11:8] are 0. A return is exactly `ir` = 0xC1C0, where bits [15:12] are 1100, the base field [8:6] is 111 and all other bits are 0. Any other pattern, such as 0xF1vv or 0xC000, starts nothing and writes no PC.
- R5: After a trap commits, `priv_mode` is 1.
- R6: A return raises `pc_we` in the same cycle with `pc_wdata` = `r7_val`. If a trap is outstanding, the mode from before that trap is restored on the next cycle.
- R7: A return with no trap outstanding sets the mode to user (0). This is how privileged code launches user code.
- R8: A system operation has bits [15:12] = 1101. In user mode it drives `wb_ok` low in its own cycle and pulses `priv_viol` high for exactly one cycle in the following cycle. In privileged mode `wb_ok` stays high and no pulse occurs.
- R9: After reset, `priv_mode` is 1, `busy` is 0, and `mem_rd`, `rf_we`, `pc_we` and `priv_viol` are 0.
- R10: While `busy` is high, `ir_valid` is ignored. A second trap or a return neither changes `mem_addr` nor alters the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_valid | input | 1 | Instruction in `ir` is issued this cycle |
| ir | input | 16 | Instruction register |
| pc_cur | input | 16 | Incremented PC of the issued instruction |
| r7_val | input | 16 | Current contents of register 7 |
| mem_addr | output | 16 | Vector table read address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| pc_we | output | 1 | PC load enable |
| pc_wdata | output | 16 | PC load value |
| priv_mode | output | 1 | 1 = privileged, 0 = user |
| busy | output | 1 | Trap sequence in progress |
| wb_ok | output | 1 | Write-back permitted for the issued instruction |
| priv_viol | output | 1 | One-cycle privilege violation pulse |

## Verification
The bench covers the vector extremes 0x00 and 0xFF. A design that sign-extended the vector or sliced the wrong bits would read the wrong table entry. It also checks that the PC receives the fetched word rather than the table address, and that the link equals the PC sampled at acceptance even when `pc_cur` changes during the sequence.

Mode handling is tested in both directions. A trap entered from privileged code must return to privileged mode, so a design that always dropped to user on return would fail. A return with no trap outstanding must drop to user mode.

The remaining cases target encoding and timing. Near-miss encodings and a trap or return issued while busy must be ignored, so a design that decoded loosely or re-armed mid-sequence would issue a stray read or commit. The violation pulse must land exactly one cycle after the offending instruction and last one cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_ADDR   = 2'd1,
      SQ_WAIT   = 2'd2,
      SQ_COMMIT = 2'd3
   } seq_st_t;

   localparam logic [3:0] OPC_TRAP = 4'b1111;
   localparam logic [3:0] OPC_JMP  = 4'b1100;
   localparam logic [3:0] OPC_SYS  = 4'b1101;
endpackage

// File: rtl/trap_decode.sv
module trap_decode #(
   parameter int AW       = 16,
   parameter int VEC_W    = 8,
   parameter int RW       = 3,
   parameter int LINK_REG = 7,
   parameter logic [3:0] OP_TRAP = trap_pkg::OPC_TRAP,
   parameter logic [3:0] OP_RET  = trap_pkg::OPC_JMP,
   parameter logic [3:0] OP_SYS  = trap_pkg::OPC_SYS
) (
   input  logic          ir_valid,
   input  logic          idle,
   input  logic [AW-1:0] ir,
   output logic          is_trap,
   output logic          is_ret,
   output logic          is_sys
);
   localparam int OPC_LO  = AW - 4;
   localparam int BASE_LO = 6;
   localparam logic [RW-1:0] LINK_IDX = RW'(LINK_REG);

   logic fire;
   logic [3:0] opc;
   logic trap_pad_zero;
   logic ret_pad_zero;

   assign fire = ir_valid && idle;
   assign opc  = ir[AW-1:OPC_LO];
   assign trap_pad_zero = (ir[OPC_LO-1:VEC_W] == '0);
   assign ret_pad_zero  = (ir[OPC_LO-1:BASE_LO+RW] == '0) && (ir[BASE_LO-1:0] == '0);

   always_comb begin
      is_trap = fire && (opc == OP_TRAP) && trap_pad_zero;
      is_ret  = fire && (opc == OP_RET) && ret_pad_zero &&
                (ir[BASE_LO+RW-1:BASE_LO] == LINK_IDX);
      is_sys  = fire && (opc == OP_SYS);
   end
endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
   parameter int AW       = 16,
   parameter int VEC_W    = 8,
   parameter int RW       = 3,
   parameter int LINK_REG = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VEC_W-1:0] vec,
   input  logic [AW-1:0]    link_in,
   input  logic [AW-1:0]    mem_rdata,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_rd,
   output logic             busy,
   output logic             commit,
   output logic [RW-1:0]    rf_waddr,
   output logic [AW-1:0]    rf_wdata,
   output logic [AW-1:0]    target
);
   import trap_pkg::*;

   localparam int PAD_W = AW - VEC_W;

   seq_st_t          st_q;
   logic [VEC_W-1:0] vec_q;
   logic [AW-1:0]    link_q;
   logic [AW-1:0]    tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         vec_q  <= '0;
         link_q <= '0;
         tgt_q  <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (start) begin
               vec_q  <= vec;
               link_q <= link_in;
               st_q   <= SQ_ADDR;
            end
            SQ_ADDR:   st_q <= SQ_WAIT;
            SQ_WAIT: begin
               tgt_q <= mem_rdata;
               st_q  <= SQ_COMMIT;
            end
            SQ_COMMIT: st_q <= SQ_IDLE;
            default:   st_q <= SQ_IDLE;
         endcase
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign mem_addr = {{PAD_W{1'b0}}, vec_q};
      end else begin : g_nopad
         assign mem_addr = vec_q;
      end
   endgenerate

   assign mem_rd   = (st_q == SQ_ADDR);
   assign busy     = (st_q != SQ_IDLE);
   assign commit   = (st_q == SQ_COMMIT);
   assign rf_waddr = RW'(LINK_REG);
   assign rf_wdata = link_q;
   assign target   = tgt_q;

   AST_READ_THEN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> ##1 commit);                                           // R3
   AST_START_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_rd && mem_addr[VEC_W-1:0] == $past(vec))); // R2
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !commit) |=> busy);                                      // R10
endmodule

// File: rtl/priv_unit.sv
module priv_unit #(
   parameter bit ENFORCE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trap_commit,
   input  logic ret_fire,
   input  logic sys_fire,
   output logic priv_mode,
   output logic wb_ok,
   output logic priv_viol
);
   generate
      if (ENFORCE) begin : g_enforce
         logic mode_q, saved_q, active_q, viol_q;
         logic blocked;

         assign blocked = sys_fire && !mode_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mode_q   <= 1'b1;
               saved_q  <= 1'b1;
               active_q <= 1'b0;
               viol_q   <= 1'b0;
            end else begin
               viol_q <= blocked;
               if (trap_commit) begin
                  saved_q  <= mode_q;
                  mode_q   <= 1'b1;
                  active_q <= 1'b1;
               end else if (ret_fire) begin
                  mode_q   <= active_q ? saved_q : 1'b0;
                  active_q <= 1'b0;
               end
            end
         end

         assign priv_mode = mode_q;
         assign wb_ok     = !blocked;
         assign priv_viol = viol_q;

         AST_TRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            trap_commit |=> priv_mode);                                 // R5
         AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
            (ret_fire && active_q) |=> (priv_mode == $past(saved_q)));  // R6
         AST_RET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (ret_fire && !active_q && !trap_commit) |=> !priv_mode);    // R7
         AST_VIOL_USER: assert property (@(posedge clk) disable iff (!rst_n)
            priv_viol |-> !$past(priv_mode));                           // R8
      end else begin : g_open
         logic unused_in;
         assign unused_in = ^{clk, rst_n, trap_commit, ret_fire, sys_fire};
         assign priv_mode = 1'b1;
         assign wb_ok     = 1'b1;
         assign priv_viol = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
   parameter int AW           = 16,
   parameter int VEC_W        = 8,
   parameter int RW           = 3,
   parameter int LINK_REG     = 7,
   parameter bit PRIV_ENFORCE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ir_valid,
   input  logic [AW-1:0] ir,
   input  logic [AW-1:0] pc_cur,
   input  logic [AW-1:0] r7_val,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   input  logic [AW-1:0] mem_rdata,
   output logic          rf_we,
   output logic [RW-1:0] rf_waddr,
   output logic [AW-1:0] rf_wdata,
   output logic          pc_we,
   output logic [AW-1:0] pc_wdata,
   output logic          priv_mode,
   output logic          busy,
   output logic          wb_ok,
   output logic          priv_viol
);
   generate
      if (VEC_W + 4 > AW) begin : g_bad_vec
         $error("trap_ctrl: vector field does not fit beside the opcode");
      end
      if (LINK_REG >= (1 << RW) || LINK_REG < 0) begin : g_bad_link
         $error("trap_ctrl: link register index out of range");
      end
      if (AW < 16) begin : g_bad_aw
         $error("trap_ctrl: word width must be at least 16");
      end
   endgenerate

   logic is_trap, is_ret, is_sys;
   logic commit;
   logic [AW-1:0] target;

   trap_decode #(.AW(AW), .VEC_W(VEC_W), .RW(RW), .LINK_REG(LINK_REG)) u_dec (
      .ir_valid (ir_valid),
      .idle     (!busy),
      .ir       (ir),
      .is_trap  (is_trap),
      .is_ret   (is_ret),
      .is_sys   (is_sys)
   );

   trap_seq #(.AW(AW), .VEC_W(VEC_W), .RW(RW), .LINK_REG(LINK_REG)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (is_trap),
      .vec       (ir[VEC_W-1:0]),
      .link_in   (pc_cur),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .busy      (busy),
      .commit    (commit),
      .rf_waddr  (rf_waddr),
      .rf_wdata  (rf_wdata),
      .target    (target)
   );

   priv_unit #(.ENFORCE(PRIV_ENFORCE)) u_priv (
      .clk         (clk),
      .rst_n       (rst_n),
      .trap_commit (commit),
      .ret_fire    (is_ret),
      .sys_fire    (is_sys),
      .priv_mode   (priv_mode),
      .wb_ok       (wb_ok),
      .priv_viol   (priv_viol)
   );

   assign rf_we    = commit;
   assign pc_we    = commit || is_ret;
   assign pc_wdata = commit ? target : r7_val;

   AST_PC_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (pc_wdata == $past(mem_rdata)));                       // R3
   AST_RET_TO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && !rf_we) |-> (pc_wdata == r7_val));                      // R6
   AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rf_we) |-> !pc_we);                                     // R10
endmodule

// File: tb/tb_trap_ctrl.sv
`timescale 1ns/1ps
module tb_trap_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ir_valid = 1'b0;
   logic [15:0] ir = '0, pc_cur = '0, r7_val = '0, mem_rdata = '0;
   logic [15:0] mem_addr, rf_wdata, pc_wdata;
   logic [2:0]  rf_waddr;
   logic        mem_rd, rf_we, pc_we, priv_mode, busy, wb_ok, priv_viol;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   localparam logic [15:0] RET = 16'hC1C0;
   localparam logic [23:0] VT [6] = '{24'h300100, 24'h3A4521, 24'h40FF25,
                                      24'h7FFEFF, 24'hFFFF80, 24'h000101};

   always #4 clk = ~clk;

   trap_ctrl dut (.clk(clk), .rst_n(rst_n), .ir_valid(ir_valid), .ir(ir),
      .pc_cur(pc_cur), .r7_val(r7_val), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
      .priv_mode(priv_mode), .busy(busy), .wb_ok(wb_ok), .priv_viol(priv_viol));

   function automatic logic [15:0] tbl(input logic [15:0] a);
      return {a[7:0] ^ 8'hA5, ~a[7:0]};
   endfunction

   always @(posedge clk) if (mem_rd) mem_rdata <= tbl(mem_addr);

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic trap(input logic [7:0] v, input logic [15:0] pc, input bit poke_busy);
      @(negedge clk); ir_valid = 1; ir = {8'hF0, v}; pc_cur = pc;
      @(negedge clk); ir_valid = 0; pc_cur = ~pc; #1;
      chk(mem_rd && mem_addr == {8'h00, v}, "R2 vector address", mem_addr, {8'h00, v});
      if (poke_busy) begin ir_valid = 1; ir = 16'hF077; r7_val = 16'h0BAD; end
      @(negedge clk); #1;
      if (poke_busy) begin
         chk(!pc_we && !mem_rd, "R10 busy ignores issue", {15'b0, pc_we}, 16'h0);
         ir = RET;
      end
      chk(busy && !rf_we && !pc_we, "R3 no early commit", {15'b0, pc_we}, 16'h0);
      @(negedge clk); ir_valid = 0; #1;
      chk(rf_we && rf_waddr == 3'd7 && rf_wdata == pc, "R1 link to R7", rf_wdata, pc);
      chk(pc_we && pc_wdata == tbl({8'h00, v}), "R3 PC from table word", pc_wdata, tbl({8'h00, v}));
      @(negedge clk); #1;
      chk(priv_mode && !busy && !pc_we && !mem_rd, "R5 privileged after trap", {15'b0, priv_mode}, 16'h1);
   endtask

   task automatic ret(input logic [15:0] link, input logic exp_mode, input string req);
      @(negedge clk); ir_valid = 1; ir = RET; r7_val = link; #1;
      chk(pc_we && !rf_we && pc_wdata == link, "R6 return loads R7", pc_wdata, link);
      @(negedge clk); ir_valid = 0; #1;
      chk(priv_mode == exp_mode, req, {15'b0, priv_mode}, {15'b0, exp_mode});
   endtask

   task automatic sys(input bit exp_block);
      @(negedge clk); ir_valid = 1; ir = 16'hD003; #1;
      chk(wb_ok == !exp_block && !priv_viol, "R8 write-back gate", {15'b0, wb_ok}, {15'b0, !exp_block});
      @(negedge clk); ir_valid = 0; #1;
      chk(priv_viol == exp_block, "R8 violation pulse", {15'b0, priv_viol}, {15'b0, exp_block});
      @(negedge clk); #1;
      chk(!priv_viol, "R8 pulse is one cycle", {15'b0, priv_viol}, 16'h0);
   endtask

   task automatic do_reset;
      rst_n = 0; ir_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      chk(priv_mode && !busy && !mem_rd && !rf_we && !pc_we && !priv_viol,
          "R9 reset state", {12'b0, priv_mode, busy, mem_rd, pc_we}, 16'h8);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      sys(1'b0);                                   // R8 privileged: allowed
      ret(16'h3000, 1'b0, "R7 return drops to user");
      sys(1'b1);                                   // R8 user: blocked
      for (int i = 0; i < 6; i++) begin
         trap(VT[i][7:0], VT[i][23:8], 1'b0);
         ret(VT[i][23:8], 1'b0, "R6 return restores user");
      end
      // R4 near-miss encodings start nothing
      @(negedge clk); ir_valid = 1; ir = 16'hF125; #1;
      chk(!pc_we, "R4 padded trap no PC write", {15'b0, pc_we}, 16'h0);
      @(negedge clk); ir = 16'hC000; #1;
      chk(!pc_we && !busy, "R4 JMP R0 not a return", {15'b0, busy}, 16'h0);
      @(negedge clk); ir_valid = 0; #1;
      chk(!busy && !mem_rd && !priv_mode, "R4 nothing started", {15'b0, busy}, 16'h0);
      // R10 issue while busy is ignored
      trap(8'h42, 16'h5555, 1'b1);
      ret(16'h5555, 1'b0, "R6 restores user after busy test");
      // R6 trap entered from privileged returns to privileged
      do_reset();
      trap(8'hFF, 16'h0200, 1'b0);
      ret(16'h0200, 1'b1, "R6 restores privileged");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule